// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Register Bank

A bank of 32-bit registers on a simple single-cycle memory-mapped bus. Every register answers at four consecutive word addresses. One word replaces the register's whole value. The other three use the write data as a bit mask that sets, clears or inverts only the selected bits. Software can therefore change individual control bits with one write and no read-modify-write sequence.

Register 0 doubles as the block's control word. Its top bit is a soft-reset request and the bit below it is a clock-gate flag. While soft reset is high, every other stored bit is forced to its default. After a fixed number of cycles the hardware raises the clock-gate flag by itself, and software polls that flag to learn that the reset has completed. The contents of all registers are presented in parallel to the logic behind the bank.

Top module: `scta_reg_bank`

## Requirements
- R1: A write (req_i=1, we_i=1) with alias field addr_i[3:2]=0 stores wdata_i unchanged in the selected register.
- R2: A write with addr_i[3:2]=1 makes each bit 1 where wdata_i is 1 and leaves all other bits unchanged.
- R3: A write with addr_i[3:2]=2 makes each bit 0 where wdata_i is 1 and leaves all other bits unchanged.
- R4: A write with addr_i[3:2]=3 inverts each bit where wdata_i is 1 and leaves all other bits unchanged.
- R5: When req_i=1 and we_i=0, rdata_o returns the stored value of the selected register in the same cycle, whatever the alias. Otherwise rdata_o is 0. A read changes no register.
- R6: The register index is addr_i[ADDR_W-1:4] and addr_i[1:0] is ignored. A cycle with req_i=0 or we_i=0 changes no register.
- R7: After hardware reset (rst_ni low), register 0 bit 31 (soft reset) is 0, bit 30 (clock gate) is 1 and bits 29:0 are RST_BASE[29:0]. Register i>0 holds RST_BASE+i.
- R8: From the first clock edge at which soft reset is already 1, and for as long as it stays 1, register 0 bits 29:0 and all other registers hold their defaults, and writes to them are ignored.
- R9: The clock-gate bit is set by hardware GATE_DELAY clock edges after the edge that stored soft reset as 1 (default 4), if software has not set it already.
- R10: A write that would clear the clock-gate bit is ignored while soft reset is 1. It is honoured while soft reset is 0.
- R11: Once soft reset is cleared, writes to all registers take effect again, beginning with the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| req_i | input | 1 | Bus request valid for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (6) | Byte address: index in [ADDR_W-1:4], alias in [3:2] |
| wdata_i | input | 32 | Write data or bit mask |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| regs_o | output | NUM_REGS*32 (128) | All register values, register i in bits [32*i+31:32*i] |
| soft_rst_o | output | 1 | Register 0 bit 31 |
| clk_gate_o | output | 1 | Register 0 bit 30 |

## Verification
The hardest case to reach is the soft-reset window. While it is open, the hardware counter and a software write both act on the clock-gate bit, and writes to other registers must be dropped. The bench clears the gate bit with soft reset low, then sets soft reset through the set alias. During the delay it sends a clear-gate write and ordinary data writes. It then clears soft reset and writes again, and a cycle-accurate model follows the gate bit on every edge.

// File: rtl/scta_pkg.sv
package scta_pkg;
  localparam int DATA_W   = 32;
  localparam int SRST_BIT = 31;
  localparam int GATE_BIT = 30;

  typedef enum logic [1:0] {
    OP_DIRECT = 2'd0,
    OP_SET    = 2'd1,
    OP_CLR    = 2'd2,
    OP_TOG    = 2'd3
  } alias_op_e;

  function automatic logic [DATA_W-1:0] apply_alias(input alias_op_e op,
                                                    input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] wd);
    case (op)
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      OP_TOG:  return cur ^ wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/scta_alias_decode.sv
module scta_alias_decode
  import scta_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = IDX_W + 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output alias_op_e         op_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              idx_ok_o,
  output logic [NUM_REGS-1:0] wr_en_o
);
  logic unused_lo;
  assign unused_lo = ^addr_i[1:0];

  assign op_o     = alias_op_e'(addr_i[3:2]);
  assign idx_o    = addr_i[ADDR_W-1:4];
  assign idx_ok_o = {1'b0, idx_o} < (IDX_W+1)'(NUM_REGS);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wr
    assign wr_en_o[g] = req_i & we_i & (idx_o == IDX_W'(g));
  end

  always_comb begin
    assert_wr_onehot_R6: assert ($onehot0(wr_en_o));
  end
endmodule

// File: rtl/scta_data_reg.sv
module scta_data_reg
  import scta_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hold_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= RST_VAL;
    else if (hold_i)  q_q <= RST_VAL;
    else if (wr_en_i) q_q <= apply_alias(op_i, q_q, wdata_i);
  end

  assign q_o = q_q;

  assert_hold_default_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (q_o == RST_VAL));

  assert_idle_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !wr_en_i) |=> $stable(q_o));
endmodule

// File: rtl/scta_ctrl_reg.sv
module scta_ctrl_reg
  import scta_pkg::*;
#(
  parameter logic [GATE_BIT-1:0] RST_LOW    = '0,
  parameter int                  GATE_DELAY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  localparam int CNT_W = $clog2(GATE_DELAY + 1);

  logic [DATA_W-1:0] q_q, nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic              srst_q, gate_q, hw_set;

  assign srst_q = q_q[SRST_BIT];
  assign gate_q = q_q[GATE_BIT];
  assign nxt    = wr_en_i ? apply_alias(op_i, q_q, wdata_i) : q_q;
  assign hw_set = srst_q && (cnt_q == CNT_W'(GATE_DELAY - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= {1'b0, 1'b1, RST_LOW};
      cnt_q <= '0;
    end else begin
      q_q[SRST_BIT] <= nxt[SRST_BIT];
      // while in soft reset the gate bit may only rise
      q_q[GATE_BIT] <= hw_set | (srst_q ? (gate_q | nxt[GATE_BIT]) : nxt[GATE_BIT]);
      q_q[GATE_BIT-1:0] <= srst_q ? RST_LOW : nxt[GATE_BIT-1:0];
      if (!srst_q)                           cnt_q <= '0;
      else if (cnt_q != CNT_W'(GATE_DELAY))  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = q_q;

  assert_gate_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q && gate_q) |=> gate_q);

  assert_gate_after_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_q && cnt_q == CNT_W'(GATE_DELAY)) |-> gate_q);

  assert_low_default_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> (q_q[GATE_BIT-1:0] == RST_LOW));
endmodule

// File: rtl/scta_reg_bank.sv
module scta_reg_bank
  import scta_pkg::*;
#(
  parameter int          NUM_REGS   = 4,
  parameter int          GATE_DELAY = 4,
  parameter logic [31:0] RST_BASE   = 32'h0000_A500,
  localparam int         IDX_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int         ADDR_W     = IDX_W + 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic [NUM_REGS*32-1:0]   regs_o,
  output logic                     soft_rst_o,
  output logic                     clk_gate_o
);
  alias_op_e           op;
  logic [IDX_W-1:0]    idx;
  logic                idx_ok;
  logic [NUM_REGS-1:0] wr_en;
  logic [31:0]         reg_q [NUM_REGS];

  scta_alias_decode #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .op_o(op), .idx_o(idx), .idx_ok_o(idx_ok), .wr_en_o(wr_en)
  );

  scta_ctrl_reg #(
    .RST_LOW(RST_BASE[GATE_BIT-1:0]), .GATE_DELAY(GATE_DELAY)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en[0]), .op_i(op),
    .wdata_i(wdata_i), .q_o(reg_q[0])
  );

  assign soft_rst_o = reg_q[0][SRST_BIT];
  assign clk_gate_o = reg_q[0][GATE_BIT];

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_data
    scta_data_reg #(
      .RST_VAL(RST_BASE + 32'(g))
    ) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en[g]), .op_i(op),
      .wdata_i(wdata_i), .hold_i(soft_rst_o), .q_o(reg_q[g])
    );
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_o[g*32 +: 32] = reg_q[g];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && idx_ok) rdata_o = reg_q[idx];
  end

  assert_read_no_effect_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !soft_rst_o) |=> $stable(regs_o));

  assert_read_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> (rdata_o == '0));
endmodule

// File: tb/scta_reg_bank_bench.sv
module scta_reg_bank_bench;
  localparam int          N     = 4;
  localparam int          DLY   = 4;
  localparam logic [31:0] BASE  = 32'h0000_A500;

  logic clk = 0;
  logic rst_ni = 0;
  logic req_i = 0, we_i = 0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N*32-1:0] regs_o;
  logic soft_rst_o, clk_gate_o;

  always #5 clk = ~clk;

  scta_reg_bank #(.NUM_REGS(N), .GATE_DELAY(DLY), .RST_BASE(BASE)) u_scta_reg_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .regs_o(regs_o),
    .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o)
  );

  int errors = 0, checks = 0;
  string cur = "R7";
  logic [31:0] m [N];
  int mcnt;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  function automatic logic [31:0] op_apply(input logic [1:0] op, input logic [31:0] c,
                                           input logic [31:0] d);
    if (op == 2'd1) return c | d;
    if (op == 2'd2) return c & ~d;
    if (op == 2'd3) return c ^ d;
    return d;
  endfunction

  function automatic logic [5:0] adr(input int ix, input int op);
    return {ix[1:0], op[1:0], 2'b00};
  endfunction

  task automatic model_reset();
    m[0] = {1'b0, 1'b1, BASE[29:0]};
    for (int i = 1; i < N; i++) m[i] = BASE + i;
    mcnt = 0;
  endtask

  task automatic model_step(input logic rq, input logic we, input logic [5:0] a,
                            input logic [31:0] d);
    logic [31:0] o0, n0;
    logic os, g, wr;
    int ix;
    o0 = m[0]; os = o0[31]; wr = rq && we; ix = a[5:4];
    n0 = (wr && ix == 0) ? op_apply(a[3:2], o0, d) : o0;
    if (os && mcnt == DLY - 1) g = 1'b1;
    else if (os)               g = o0[30] | n0[30];
    else                       g = n0[30];
    m[0] = {n0[31], g, os ? BASE[29:0] : n0[29:0]};
    for (int i = 1; i < N; i++) begin
      if (os) m[i] = BASE + i;
      else if (wr && ix == i) m[i] = op_apply(a[3:2], m[i], d);
    end
    if (!os) mcnt = 0;
    else if (mcnt < DLY) mcnt++;
  endtask

  task automatic cmp_all();
    for (int i = 0; i < N; i++) chk($sformatf("reg%0d", i), regs_o[i*32 +: 32], m[i]);
    chk("soft_rst", {31'd0, soft_rst_o}, {31'd0, m[0][31]});
    chk("clk_gate", {31'd0, clk_gate_o}, {31'd0, m[0][30]});
  endtask

  task automatic cyc(input logic rq, input logic we, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = rq; we_i = we; addr_i = a; wdata_i = d;
    #1;
    if (rq && !we) chk("rdata (R5)", rdata_o, m[a[5:4]]);
    else           chk("rdata idle (R5)", rdata_o, 32'd0);
    @(posedge clk);
    model_step(rq, we, a, d);
    #1;
    cmp_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    cur = "R7"; cmp_all();

    cur = "R1";
    cyc(1, 1, adr(1, 0), 32'hDEAD_BEEF);
    cyc(1, 1, adr(2, 0), 32'h0F0F_00FF);
    cyc(1, 1, adr(3, 0), 32'h8000_0001);
    cyc(1, 1, adr(0, 0), 32'h1234_5678);
    cur = "R5";
    for (int op = 0; op < 4; op++) cyc(1, 0, adr(1, op), 32'hFFFF_FFFF);
    cyc(1, 0, adr(0, 2), 32'h0);
    cur = "R2";
    cyc(1, 1, adr(2, 1), 32'hF000_0F00);
    cyc(1, 1, adr(0, 1), 32'h0000_0003);
    cur = "R3";
    cyc(1, 1, adr(2, 2), 32'h0F00_00F0);
    cyc(1, 1, adr(1, 2), 32'h0000_FFFF);
    cur = "R4";
    cyc(1, 1, adr(3, 3), 32'hFFFF_0000);
    cyc(1, 1, adr(0, 3), 32'h4000_0001);
    cur = "R6";
    cyc(0, 1, adr(1, 0), 32'h1111_1111);
    cyc(1, 0, adr(3, 0) | 6'b11, 32'h2222_2222);
    cyc(1, 1, adr(2, 0) | 6'b10, 32'h3333_3333);
    cyc(1, 1, adr(0, 2), 32'h4000_0000);  // gate low before soft reset
    cur = "R8";
    cyc(1, 1, adr(0, 1), 32'h8000_0000);
    cyc(1, 1, adr(1, 0), 32'h5555_5555);
    cur = "R10";
    cyc(1, 1, adr(0, 2), 32'h4000_0000);
    cur = "R9";
    for (int i = 0; i < DLY + 2; i++) cyc(0, 0, 6'd0, 32'd0);
    chk("gate after delay", {31'd0, clk_gate_o}, 32'd1);
    cur = "R10";
    cyc(1, 1, adr(0, 2), 32'h4000_0000);
    cur = "R11";
    cyc(1, 1, adr(0, 2), 32'h8000_0000);
    cyc(1, 1, adr(1, 0), 32'h6666_7777);
    cyc(1, 1, adr(3, 1), 32'h0000_00F0);
    cur = "R10";
    cyc(1, 1, adr(0, 2), 32'h4000_0000);
    chk("gate cleared", {31'd0, clk_gate_o}, 32'd0);
    cur = "R9";
    cyc(1, 1, adr(0, 0), 32'h8000_0000);
    for (int i = 0; i < DLY + 1; i++) cyc(1, 0, adr(2, 0), 32'd0);
    cur = "R11";
    cyc(1, 1, adr(0, 0), 32'h0000_0000);
    cyc(1, 1, adr(2, 3), 32'hAAAA_AAAA);

    cur = "R7";
    @(negedge clk); rst_ni = 0; req_i = 0; we_i = 0;
    model_reset();
    #1; cmp_all();
    @(negedge clk); rst_ni = 1;
    #1; cmp_all();

    summary();
    $finish;
  end
endmodule